// File: doc/BRIEF.md
# Parallel Host Bus Front End

This block is the digital front end of a combined converter peripheral that sits on an 8-bit parallel host bus. It takes the active-low chip select, read, write and host-clear strobes and a falling-edge start trigger from the host. It holds the code that sets the output converter, and it presents the last conversion result on a three-state data bus. The bus is modelled as separate data-in, data-out and output-enable signals. The block runs the active-low completion interrupt, requests conversions from a separate sequencer, and decodes a 2-bit channel number into a one-hot select for a four-input analog mux.

Every host strobe and the data lines pass through a two-stage synchronizer into the system clock domain. Edge detectors on the synchronized strobes produce single-cycle load, release and start pulses. A conversion starts in one of two ways. The host can pull the start trigger low, and this trigger is not qualified by chip select. Or, with the trigger parked high, the host can begin a read cycle, and that read both starts a conversion and collects the data. The host-clear input acts at once, without the clock. It empties the code register and withdraws the interrupt, and it leaves any conversion in progress alone.

Top module: `pbus_frontend`

## Requirements
- R1: `dac_code` takes the value `bus_din` had at the first clock edge that sampled `bus_wr_n` high after being low. This load happens only if `bus_cs_n` was low at the sampled edge. The new code is visible after the third rising clock edge from the `bus_wr_n` rise. A write strobe with `bus_cs_n` high is ignored.
- R2: While `bus_cs_n` and `bus_wr_n` are both held low, changes on `bus_din` leave `dac_code` unchanged.
- R3: `bus_clr_n` low clears `dac_code` to 0 at once, without waiting for a clock edge. Writes are ignored while `bus_clr_n` is low and for the two clock edges after its release. After that, the code stays 0 until the next accepted write.
- R4: `bus_clr_n` low drives `irq_n` high at once. It does not affect a conversion in progress: a result that arrives after the clear still loads the output latch and pulls `irq_n` low.
- R5: `irq_n` goes low on the clock edge that samples `conv_done` high. It returns high one edge after the synchronized rising edge of either `bus_cs_n` or `bus_rd_n`. When both happen on the same edge, the completion wins.
- R6: `bus_oe` is high exactly while the synchronized `bus_cs_n` and `bus_rd_n` are both low. `bus_dout` carries the output latch when `bus_oe` is high and is 0 otherwise.
- R7: The output latch changes only on a cycle with `conv_done` high, when it loads `conv_result`. A read made during a conversion therefore returns the previous result.
- R8: A synchronized falling edge of `start_n` gives a one-cycle `conv_start` pulse, whatever the state of `bus_cs_n`.
- R9: A synchronized falling edge of `bus_rd_n` gives a one-cycle `conv_start` pulse, provided synchronized `bus_cs_n` is low and synchronized `start_n` is high at that point.
- R10: No `conv_start` pulse is issued on a cycle that follows a cycle with `conv_busy` high. Start events that arrive during a conversion are dropped.
- R11: `mux_sel` is one-hot. `chan_sel` value 0 selects bit 0, 1 selects bit 1, 2 selects bit 2 and 3 selects bit 3, all combinationally.
- R12: `dac_warn` is 0 after `rst_n`. It becomes 1, and stays 1 until `rst_n`, when a write is accepted while `conv_busy` is high. Such a write still updates `dac_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| bus_cs_n | input | 1 | Host chip select, active low |
| bus_rd_n | input | 1 | Host read strobe, active low |
| bus_wr_n | input | 1 | Host write strobe, loads on its rising edge |
| bus_clr_n | input | 1 | Host clear, active low, asynchronous |
| start_n | input | 1 | Conversion trigger, acts on its falling edge |
| chan_sel | input | 2 | Analog channel number |
| bus_din | input | 8 | Data driven by the host |
| conv_busy | input | 1 | Sequencer is converting |
| conv_done | input | 1 | One-cycle completion pulse from the sequencer |
| conv_result | input | 8 | Result that goes with `conv_done` |
| bus_dout | output | 8 | Read data toward the host |
| bus_oe | output | 1 | Drive enable for the bus pads |
| dac_code | output | 8 | Code held for the output converter |
| irq_n | output | 1 | Completion interrupt, active low |
| conv_start | output | 1 | One-cycle conversion request |
| mux_sel | output | 4 | One-hot analog mux select |
| dac_warn | output | 1 | Sticky flag: write accepted during a conversion |

## Verification
Some properties are checked on every cycle. A low host clear must show as a zero code and a high interrupt. The result latch and the code register must hold still without their load events. The interrupt may fall only after a completion, no start request may follow a busy cycle, and the warning flag must stay set. Other behaviours need the scenarios driven against the cycle-by-cycle reference model. These are the three-edge write latency, that a level-held write strobe does nothing, and the two start paths with and without chip select. The scenarios also show old data during a read-started conversion, that an ignored write sits under the clear, and that a conversion carries on through a host clear.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

  localparam int CTL_W = 4;

  typedef struct packed {
    logic st_n;
    logic wr_n;
    logic rd_n;
    logic cs_n;
  } ctl_t;

  localparam ctl_t CTL_IDLE = '{st_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, cs_n: 1'b1};

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
  parameter int           W       = 1,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];

endmodule

// File: rtl/pbus_dac_reg.sv
module pbus_dac_reg #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrst_n,
  input  logic          load,
  input  logic          busy,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] code,
  output logic          warn
);

  logic [DW-1:0] code_q, code_d;
  logic          warn_q, warn_d;

  always_comb begin
    code_d = code_q;
    if (load) code_d = wdata;
    warn_d = warn_q | (load & busy & lrst_n);
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) code_q <= '0;
    else         code_q <= code_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_d;
  end

  assign code = code_q;
  assign warn = warn_q;

  // R1: an accepted load shows the captured bus data on the next cycle
  p_load_value_r1: assert property (@(posedge clk) disable iff (!lrst_n)
    load |=> (code_q == $past(wdata)));

  // R2: without a load event the code register holds
  p_code_hold_r2: assert property (@(posedge clk) disable iff (!lrst_n)
    !load |=> $stable(code_q));

  // R12: warning flag is sticky until system reset
  p_warn_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
    warn_q |=> warn_q);

endmodule

// File: rtl/pbus_irq_ctl.sv
module pbus_irq_ctl #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lrst_n,
  input  logic          done,
  input  logic [DW-1:0] result,
  input  logic          rel_ev,
  output logic          irq_n,
  output logic [DW-1:0] rdata
);

  logic          irq_q, irq_d;
  logic [DW-1:0] rdata_q, rdata_d;

  always_comb begin
    irq_d = irq_q;
    if (done)        irq_d = 1'b0;
    else if (rel_ev) irq_d = 1'b1;
    rdata_d = rdata_q;
    if (done) rdata_d = result;
  end

  always_ff @(posedge clk or negedge lrst_n) begin
    if (!lrst_n) irq_q <= 1'b1;
    else         irq_q <= irq_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rdata_d;
  end

  assign irq_n = irq_q;
  assign rdata = rdata_q;

  // R5: interrupt falls only after a completion pulse
  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!lrst_n)
    $fell(irq_q) |-> $past(done));

  // R7: result latch keeps old data between completions
  p_old_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(rdata_q));

endmodule

// File: rtl/pbus_frontend.sv
module pbus_frontend
  import pbus_pkg::*;
#(
  parameter int DW          = 8,
  parameter int CH_W        = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs_n,
  input  logic                 bus_rd_n,
  input  logic                 bus_wr_n,
  input  logic                 bus_clr_n,
  input  logic                 start_n,
  input  logic [CH_W-1:0]      chan_sel,
  input  logic [DW-1:0]        bus_din,
  input  logic                 conv_busy,
  input  logic                 conv_done,
  input  logic [DW-1:0]        conv_result,
  output logic [DW-1:0]        bus_dout,
  output logic                 bus_oe,
  output logic [DW-1:0]        dac_code,
  output logic                 irq_n,
  output logic                 conv_start,
  output logic [(1<<CH_W)-1:0] mux_sel,
  output logic                 dac_warn
);

  localparam int NCH = 1 << CH_W;
  localparam int SW  = DW + CTL_W;

  ctl_t          ctl_raw, ctl_s, ctl_p;
  logic [DW-1:0] din_s;
  logic [SW-1:0] sync_q;
  logic          lrst_n;
  logic          wr_load, rel_ev, st_fall, rd_start;
  logic          start_q, start_d;
  logic [DW-1:0] rdata;

  assign ctl_raw = ctl_t'({start_n, bus_wr_n, bus_rd_n, bus_cs_n});

  // Strobes and data share one synchronizer so they stay aligned
  pbus_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({{DW{1'b0}}, CTL_IDLE})) u_in_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({bus_din, ctl_raw}),
    .q     (sync_q)
  );
  assign {din_s, ctl_s} = sync_q;

  // Local reset: asserts with rst_n or host clear, releases on the clock
  pbus_sync #(.W(1), .STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n & bus_clr_n),
    .d     (1'b1),
    .q     (lrst_n)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_p <= CTL_IDLE;
    else        ctl_p <= ctl_s;
  end

  always_comb begin
    wr_load  = ctl_s.wr_n & ~ctl_p.wr_n & ~ctl_s.cs_n;
    rel_ev   = (ctl_s.cs_n & ~ctl_p.cs_n) | (ctl_s.rd_n & ~ctl_p.rd_n);
    st_fall  = ~ctl_s.st_n & ctl_p.st_n;
    rd_start = ~ctl_s.rd_n & ctl_p.rd_n & ~ctl_s.cs_n & ctl_s.st_n;
    start_d  = ~conv_busy & (st_fall | rd_start);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= 1'b0;
    else        start_q <= start_d;
  end

  pbus_dac_reg #(.DW(DW)) u_dac (
    .clk    (clk),
    .rst_n  (rst_n),
    .lrst_n (lrst_n),
    .load   (wr_load),
    .busy   (conv_busy),
    .wdata  (din_s),
    .code   (dac_code),
    .warn   (dac_warn)
  );

  pbus_irq_ctl #(.DW(DW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .lrst_n (lrst_n),
    .done   (conv_done),
    .result (conv_result),
    .rel_ev (rel_ev),
    .irq_n  (irq_n),
    .rdata  (rdata)
  );

  assign bus_oe     = ~ctl_s.cs_n & ~ctl_s.rd_n;
  assign bus_dout   = bus_oe ? rdata : '0;
  assign conv_start = start_q;

  for (genvar i = 0; i < NCH; i++) begin : g_mux
    assign mux_sel[i] = (chan_sel == CH_W'(i));
  end

  // R3: host clear holds the code register at zero
  p_clr_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clr_n |-> (dac_code == '0));

  // R4: host clear holds the interrupt released
  p_clr_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_clr_n |-> irq_n);

  // R10: no start request right after a busy cycle
  p_no_start_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !$past(conv_busy));

endmodule

// File: tb/sim_pbus_frontend.sv
`timescale 1ns/1ps
module sim_pbus_frontend;

  logic       clk = 1'b0;
  logic       rst_n, bus_cs_n, bus_rd_n, bus_wr_n, bus_clr_n, start_n;
  logic [1:0] chan_sel;
  logic [7:0] bus_din, conv_result;
  logic       conv_busy, conv_done;
  logic [7:0] bus_dout, dac_code;
  logic       bus_oe, irq_n, conv_start, dac_warn;
  logic [3:0] mux_sel;

  always #2.5 clk = ~clk;

  pbus_frontend u0 (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_wr_n(bus_wr_n), .bus_clr_n(bus_clr_n), .start_n(start_n),
    .chan_sel(chan_sel), .bus_din(bus_din), .conv_busy(conv_busy),
    .conv_done(conv_done), .conv_result(conv_result), .bus_dout(bus_dout),
    .bus_oe(bus_oe), .dac_code(dac_code), .irq_n(irq_n),
    .conv_start(conv_start), .mux_sel(mux_sel), .dac_warn(dac_warn)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural conversion sequencer
  int         seq_cnt;
  logic [7:0] res_next = 8'h11;
  logic [7:0] last_result = 8'h00;
  always @(negedge clk) begin
    if (!rst_n) begin
      conv_busy = 1'b0; conv_done = 1'b0; seq_cnt = 0; conv_result = 8'h00;
    end else if (conv_busy) begin
      if (seq_cnt == 1) begin
        conv_busy = 1'b0; conv_done = 1'b1;
        conv_result = res_next; last_result = res_next;
        res_next = res_next + 8'h26;
      end else seq_cnt--;
    end else begin
      conv_done = 1'b0;
      if (conv_start) begin conv_busy = 1'b1; seq_cnt = 8; end
    end
  end

  // Cycle-by-cycle reference model: sampled history of the bus pins
  bit hcs[4], hrd[4], hwr[4], hst[4];
  int hdin[4];
  int m_dac, m_lat;
  bit m_irq, m_warn, m_start, lr1, lr2, lr_old;
  int n_starts = 0;

  always @(posedge clk) begin
    #1;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        hcs[i] = 1; hrd[i] = 1; hwr[i] = 1; hst[i] = 1; hdin[i] = 0;
      end
      m_dac = 0; m_lat = 0; m_irq = 1; m_warn = 0; m_start = 0; lr1 = 0; lr2 = 0;
    end else begin
      bit ld, rel, stf, rdf;
      for (int i = 3; i > 0; i--) begin
        hcs[i] = hcs[i-1]; hrd[i] = hrd[i-1]; hwr[i] = hwr[i-1];
        hst[i] = hst[i-1]; hdin[i] = hdin[i-1];
      end
      hcs[0] = bus_cs_n; hrd[0] = bus_rd_n; hwr[0] = bus_wr_n;
      hst[0] = start_n; hdin[0] = int'(bus_din);
      if (!bus_clr_n) begin lr1 = 0; lr2 = 0; end
      lr_old = lr2;
      ld  = hwr[2] && !hwr[3] && !hcs[2];
      rel = (hcs[2] && !hcs[3]) || (hrd[2] && !hrd[3]);
      stf = !hst[2] && hst[3];
      rdf = !hrd[2] && hrd[3] && !hcs[2] && hst[2];
      if (!lr_old) m_dac = 0; else if (ld) m_dac = hdin[2];
      if (ld && lr_old && conv_busy) m_warn = 1;
      if (!lr_old) m_irq = 1; else if (conv_done) m_irq = 0; else if (rel) m_irq = 1;
      if (conv_done) m_lat = int'(conv_result);
      m_start = !conv_busy && (stf || rdf);
      if (bus_clr_n) begin lr2 = lr1; lr1 = 1; end
    end
    if (conv_start) n_starts++;
    begin
      bit oe_e;
      oe_e = !hcs[1] && !hrd[1];
      chk(dac_code == 8'(m_dac), "R1 model dac_code", dac_code, m_dac);
      chk(irq_n == m_irq, "R5 model irq_n", irq_n, m_irq);
      chk(bus_oe == oe_e, "R6 model bus_oe", bus_oe, oe_e);
      chk(bus_dout == (oe_e ? 8'(m_lat) : 8'h00), "R7 model bus_dout", bus_dout, oe_e ? m_lat : 0);
      chk(conv_start == m_start, "R9 model conv_start", conv_start, m_start);
      chk(dac_warn == m_warn, "R12 model dac_warn", dac_warn, m_warn);
      chk(mux_sel == 4'(1 << chan_sel), "R11 model mux_sel", mux_sel, 1 << chan_sel);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] v);
    bus_cs_n = 1'b0; bus_din = v; bus_wr_n = 1'b0;
    cyc(2);
    bus_wr_n = 1'b1;
    cyc(3);
    bus_cs_n = 1'b1; bus_din = 8'h00;
    cyc(1);
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired at %0t", $time);
    finish_run();
  end

  initial begin
    int s0;
    logic [7:0] r1;
    rst_n = 1'b0; bus_clr_n = 1'b1; bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    bus_wr_n = 1'b1; start_n = 1'b1; bus_din = 8'h00; chan_sel = 2'd0;
    cyc(4);
    rst_n = 1'b1;
    #1;
    chk(dac_code == 8'h00, "R1 reset dac_code", dac_code, 0);
    chk(irq_n == 1'b1, "R5 reset irq_n", irq_n, 1);
    chk(bus_oe == 1'b0, "R6 reset bus_oe", bus_oe, 0);
    chk(dac_warn == 1'b0, "R12 reset dac_warn", dac_warn, 0);
    cyc(2);

    // R1: basic write
    bus_write(8'hA5);
    chk(dac_code == 8'hA5, "R1 write A5", dac_code, 8'hA5);

    // R2: bus changes under level-held strobes
    bus_cs_n = 1'b0; bus_wr_n = 1'b0; bus_din = 8'h5A;
    cyc(2);
    bus_din = 8'hC3;
    cyc(2);
    chk(dac_code == 8'hA5, "R2 level hold", dac_code, 8'hA5);
    bus_wr_n = 1'b1;
    cyc(3);
    chk(dac_code == 8'hC3, "R1 write C3 on rise", dac_code, 8'hC3);
    bus_cs_n = 1'b1;
    cyc(2);

    // R1: write strobe with chip select high is ignored
    bus_wr_n = 1'b0; bus_din = 8'h11;
    cyc(2);
    bus_wr_n = 1'b1;
    cyc(3);
    chk(dac_code == 8'hC3, "R1 cs high ignored", dac_code, 8'hC3);
    chk(dac_warn == 1'b0, "R12 idle writes no warn", dac_warn, 0);

    // R8: trigger start without chip select
    s0 = n_starts;
    start_n = 1'b0; cyc(2); start_n = 1'b1;
    cyc(14);
    chk(n_starts == s0 + 1, "R8 trigger start", n_starts, s0 + 1);
    chk(irq_n == 1'b0, "R5 irq after done", irq_n, 0);
    r1 = last_result;

    // R6/R9/R7: read-started conversion, old then new data
    bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    cyc(3);
    chk(bus_oe == 1'b1, "R6 oe during read", bus_oe, 1);
    chk(bus_dout == r1, "R6 read data", bus_dout, r1);
    chk(n_starts == s0 + 2, "R9 read starts conversion", n_starts, s0 + 2);
    cyc(2);
    chk(conv_busy == 1'b1, "R7 conversion running", conv_busy, 1);
    chk(bus_dout == r1, "R7 old data while busy", bus_dout, r1);
    start_n = 1'b0; cyc(1); start_n = 1'b1;
    cyc(3);
    chk(n_starts == s0 + 2, "R10 start dropped while busy", n_starts, s0 + 2);
    cyc(10);
    chk(bus_dout == last_result, "R7 new data after done", bus_dout, last_result);
    chk(irq_n == 1'b0, "R5 irq low while read held", irq_n, 0);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    cyc(3);
    chk(irq_n == 1'b1, "R5 release on cs/rd rise", irq_n, 1);
    chk(bus_oe == 1'b0, "R6 oe off", bus_oe, 0);

    // R12: write during a conversion
    start_n = 1'b0; cyc(1); start_n = 1'b1;
    bus_write(8'h3E);
    chk(dac_code == 8'h3E, "R12 busy write performed", dac_code, 8'h3E);
    chk(dac_warn == 1'b1, "R12 warn set", dac_warn, 1);
    cyc(14);
    chk(dac_warn == 1'b1, "R12 warn sticky", dac_warn, 1);

    // R3/R4: host clear
    chk(irq_n == 1'b0, "R5 irq pending before clear", irq_n, 0);
    bus_clr_n = 1'b0;
    #1;
    chk(dac_code == 8'h00, "R3 async clear code", dac_code, 0);
    chk(irq_n == 1'b1, "R4 async clear irq", irq_n, 1);
    cyc(1);
    bus_write(8'h99);
    chk(dac_code == 8'h00, "R3 write ignored under clear", dac_code, 0);
    bus_clr_n = 1'b1;
    cyc(3);
    chk(dac_code == 8'h00, "R3 stays zero after release", dac_code, 0);
    bus_write(8'h77);
    chk(dac_code == 8'h77, "R3 next write loads", dac_code, 8'h77);

    // R4: conversion continues through a clear
    start_n = 1'b0; cyc(1); start_n = 1'b1;
    cyc(4);
    bus_clr_n = 1'b0; cyc(2); bus_clr_n = 1'b1;
    cyc(12);
    chk(irq_n == 1'b0, "R4 completion after clear", irq_n, 0);
    bus_cs_n = 1'b0; bus_rd_n = 1'b0;
    cyc(3);
    chk(bus_dout == last_result, "R4 result kept", bus_dout, last_result);
    bus_cs_n = 1'b1; bus_rd_n = 1'b1;
    cyc(14);

    // R11: channel decode
    for (int ch = 0; ch < 4; ch++) begin
      chan_sel = 2'(ch);
      #1;
      chk(mux_sel == 4'(1 << ch), "R11 channel decode", mux_sel, 1 << ch);
      cyc(1);
    end
    cyc(4);
    finish_run();
  end

endmodule